// File: doc/BRIEF.md
# Address-Space-Tagged Translation Lookaside Buffer

This block is a small, fully associative cache of address translations. A lookup presents a virtual address, the identifier of the running address space and the access kind: load or store, user or kernel mode. One clock later the block returns a physical address, a hit flag, a cacheability flag and a two-bit fault code. Every stored entry is compared against the request in the same cycle. An entry matches when it is valid, its virtual page number equals the request's, and either its address-space identifier equals the request's or its global flag is set. Because entries are tagged this way, a context switch only changes the identifier presented with each lookup. No flush is needed.

The three top address bits select a region. Top bits 0xx are the user region and 11x are the kernel-mapped region; both are translated through the entries. Top bits 100 and 101 are kernel windows that bypass the entries. They map directly to the low physical space, the first as cacheable and the second as uncacheable. The block does not walk page tables. A miss is reported as a fault so that software can refill an entry. Software fills entries through a write port, either at an index it chooses or at a rotating replacement index. That index never points into a reserved low range of wired entries. An invalidate-by-page port and an invalidate-all input let software keep the entries consistent when page tables change.

Top module: `asid_tlb`

## Requirements
- R1: While `rst` is high and in the first cycle after it is released, `rsp_valid` is 0 and `rand_idx` equals ENTRIES-1 (63). No entry is valid after reset, so a lookup in a mapped region then returns fault code 1.
- R2: A lookup that is not an address error and whose top three address bits are 100 or 101 uses no entry. It returns `rsp_hit`=0 and fault code 0, and `rsp_paddr` is the virtual address with its top three bits cleared. `rsp_cached` is 1 for 100 and 0 for 101.
- R3: A lookup in a mapped region (top bits 0xx or 11x) hits when an entry is valid, its page number equals address bits [31:12], and either its identifier equals `lk_asid` or its global flag is set. A hit returns `rsp_hit`=1 and `rsp_paddr` = {entry frame, address bits [11:0]}. It also returns `rsp_cached` = NOT the entry's no-cache flag and fault code 0, unless R5 applies. The result appears on the clock edge after the edge that samples the request. When several entries match, the lowest index supplies the result.
- R4: A mapped lookup that finds no matching entry returns `rsp_hit`=0, fault code 1 (miss), `rsp_paddr`=0 and `rsp_cached`=0. This includes an identifier mismatch on a non-global entry.
- R5: A store (`lk_store`=1) that hits an entry whose dirty/writeable flag is 0 returns fault code 2 (modify), `rsp_hit`=1, `rsp_paddr`=0 and `rsp_cached`=0. A load that hits the same entry completes normally.
- R6: A user-mode lookup (`lk_user`=1) with address bit 31 set returns fault code 3 (address error), `rsp_hit`=0, `rsp_paddr`=0 and `rsp_cached`=0. This takes precedence over every other outcome.
- R7: `rand_idx` decreases by one on every clock edge. After reaching WIRED (8) it reloads ENTRIES-1 on the next edge, so it never falls below WIRED.
- R8: With `wr_en`=1 the entry is written at `wr_index`, or at the current `rand_idx` value when `wr_random`=1. The new contents are visible to lookups from the next cycle on.
- R9: `inv_en` clears the valid flag of every entry whose page number equals `inv_vpn`, whatever its identifier. Other entries keep their contents.
- R10: `flush_all` clears every entry. A write in the same cycle still lands.
- R11: A lookup sampled on the same edge as a write, invalidate or flush sees the entries as they were before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request present |
| lk_vaddr | input | 32 | Virtual address |
| lk_asid | input | 6 | Current address-space identifier |
| lk_store | input | 1 | 1 = store, 0 = load |
| lk_user | input | 1 | 1 = user mode, 0 = kernel mode |
| wr_en | input | 1 | Write one entry |
| wr_random | input | 1 | Use `rand_idx` instead of `wr_index` |
| wr_index | input | 6 | Entry chosen by software |
| wr_vpn | input | 20 | Page number to store |
| wr_asid | input | 6 | Identifier to store |
| wr_pfn | input | 20 | Physical frame to store |
| wr_global | input | 1 | Entry matches any identifier |
| wr_dirty | input | 1 | Entry may be stored to |
| wr_nocache | input | 1 | Entry is uncacheable |
| wr_valid | input | 1 | Valid flag to store |
| inv_en | input | 1 | Invalidate entries matching `inv_vpn` |
| inv_vpn | input | 20 | Page number to invalidate |
| flush_all | input | 1 | Invalidate all entries |
| rsp_valid | output | 1 | Response present (lookup of previous cycle) |
| rsp_paddr | output | 32 | Physical address |
| rsp_hit | output | 1 | Mapped translation found |
| rsp_cached | output | 1 | Access may be cached |
| rsp_fault | output | 2 | 0 none, 1 miss, 2 modify, 3 address error |
| rand_idx | output | 6 | Current replacement index |

## Verification
A stale or misplaced entry cannot hide for long. On the next lookup of that page it shows up as a wrong frame, a miss where a hit was due, or a hit that survived an invalidate. The reference model therefore repeats lookups right after every write, invalidate and flush. A replacement counter that drifts shows up on `rand_idx` in the very cycle it goes wrong, and a random write then lands in an entry other than the one the model expects. The mixed random phase keeps a small page pool so that identifier mismatches, global matches, several matching entries and modify faults recur many times.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;
  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_MISS = 2'd1,
    FLT_MOD  = 2'd2,
    FLT_ADDR = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    SEG_USER,
    SEG_KDIR_C,
    SEG_KDIR_U,
    SEG_KMAP
  } seg_e;
endpackage

// File: rtl/tlb_region_dec.sv
module tlb_region_dec
  import asid_tlb_pkg::*;
(
  input  logic [2:0] top_bits,
  input  logic       user_mode,
  output seg_e       seg,
  output logic       mapped,
  output logic       addr_err
);
  always_comb begin
    if (!top_bits[2])            seg = SEG_USER;
    else if (top_bits[1])        seg = SEG_KMAP;
    else if (!top_bits[0])       seg = SEG_KDIR_C;
    else                         seg = SEG_KDIR_U;
    mapped   = (seg == SEG_USER) || (seg == SEG_KMAP);
    addr_err = user_mode && top_bits[2];
  end
endmodule

// File: rtl/tlb_rand_idx.sv
module tlb_rand_idx #(
  parameter int ENTRIES = 64,
  parameter int WIRED   = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] TOP = IDX_W'(ENTRIES - 1);
  localparam logic [IDX_W-1:0] LOW = IDX_W'(WIRED);

  always_ff @(posedge clk) begin
    if (rst)             idx <= TOP;
    else if (idx == LOW) idx <= TOP;
    else                 idx <= idx - 1'b1;
  end
endmodule

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 6,
  parameter int PFN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [PFN_W-1:0]  wr_pfn,
  input  logic              wr_global,
  input  logic              wr_dirty,
  input  logic              wr_nocache,
  input  logic              wr_valid,
  input  logic              inv_en,
  input  logic [VPN_W-1:0]  inv_vpn,
  input  logic              flush,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              hit,
  output logic [PFN_W-1:0]  hit_pfn,
  output logic              hit_dirty,
  output logic              hit_nocache
);
  logic [ENTRIES-1:0] vld;
  logic [ENTRIES-1:0] glb;
  logic [ENTRIES-1:0] drt;
  logic [ENTRIES-1:0] ncf;
  logic [VPN_W-1:0]   tag_vpn  [ENTRIES];
  logic [ASID_W-1:0]  tag_asid [ENTRIES];
  logic [PFN_W-1:0]   frame    [ENTRIES];
  logic [ENTRIES-1:0] match;

  // Valid flags: reset, flush and page invalidate, then a write overrides.
  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (flush || (inv_en && tag_vpn[i] == inv_vpn)) vld[i] <= 1'b0;
      end
      if (wr_en) vld[wr_idx] <= wr_valid;
    end
  end

  // Entry payload: no reset, written like a memory.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_vpn[wr_idx]  <= wr_vpn;
      tag_asid[wr_idx] <= wr_asid;
      frame[wr_idx]    <= wr_pfn;
      glb[wr_idx]      <= wr_global;
      drt[wr_idx]      <= wr_dirty;
      ncf[wr_idx]      <= wr_nocache;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = vld[g] && (tag_vpn[g] == lk_vpn) &&
                      (glb[g] || (tag_asid[g] == lk_asid));
  end

  // Lowest matching index wins.
  always_comb begin
    hit         = |match;
    hit_pfn     = '0;
    hit_dirty   = 1'b0;
    hit_nocache = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_pfn     = frame[i];
        hit_dirty   = drt[i];
        hit_nocache = ncf[i];
      end
    end
  end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import asid_tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int WIRED   = 8,
  parameter int VPN_W   = 20,
  parameter int OFF_W   = 12,
  parameter int ASID_W  = 6,
  parameter int PFN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int VA_W   = VPN_W + OFF_W,
  localparam int PA_W   = PFN_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              lk_store,
  input  logic              lk_user,
  input  logic              wr_en,
  input  logic              wr_random,
  input  logic [IDX_W-1:0]  wr_index,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [PFN_W-1:0]  wr_pfn,
  input  logic              wr_global,
  input  logic              wr_dirty,
  input  logic              wr_nocache,
  input  logic              wr_valid,
  input  logic              inv_en,
  input  logic [VPN_W-1:0]  inv_vpn,
  input  logic              flush_all,
  output logic              rsp_valid,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              rsp_hit,
  output logic              rsp_cached,
  output logic [1:0]        rsp_fault,
  output logic [IDX_W-1:0]  rand_idx
);
  seg_e              seg;
  logic              mapped;
  logic              addr_err;
  logic              cam_hit;
  logic [PFN_W-1:0]  cam_pfn;
  logic              cam_dirty;
  logic              cam_nc;
  logic [IDX_W-1:0]  wr_sel;

  logic [PA_W-1:0]   nx_paddr;
  logic              nx_hit;
  logic              nx_cached;
  fault_e            nx_fault;

  tlb_region_dec u_dec (
    .top_bits (lk_vaddr[VA_W-1 -: 3]),
    .user_mode(lk_user),
    .seg      (seg),
    .mapped   (mapped),
    .addr_err (addr_err)
  );

  tlb_rand_idx #(.ENTRIES(ENTRIES), .WIRED(WIRED)) u_rnd (
    .clk(clk),
    .rst(rst),
    .idx(rand_idx)
  );

  assign wr_sel = wr_random ? rand_idx : wr_index;

  tlb_cam #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W)
  ) u_cam (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_idx     (wr_sel),
    .wr_vpn     (wr_vpn),
    .wr_asid    (wr_asid),
    .wr_pfn     (wr_pfn),
    .wr_global  (wr_global),
    .wr_dirty   (wr_dirty),
    .wr_nocache (wr_nocache),
    .wr_valid   (wr_valid),
    .inv_en     (inv_en),
    .inv_vpn    (inv_vpn),
    .flush      (flush_all),
    .lk_vpn     (lk_vaddr[VA_W-1 -: VPN_W]),
    .lk_asid    (lk_asid),
    .hit        (cam_hit),
    .hit_pfn    (cam_pfn),
    .hit_dirty  (cam_dirty),
    .hit_nocache(cam_nc)
  );

  always_comb begin
    nx_paddr  = '0;
    nx_hit    = 1'b0;
    nx_cached = 1'b0;
    nx_fault  = FLT_NONE;
    if (addr_err) begin
      nx_fault = FLT_ADDR;
    end else if (!mapped) begin
      nx_paddr  = PA_W'(lk_vaddr[VA_W-4:0]);
      nx_cached = (seg == SEG_KDIR_C);
    end else if (!cam_hit) begin
      nx_fault = FLT_MISS;
    end else begin
      nx_hit = 1'b1;
      if (lk_store && !cam_dirty) begin
        nx_fault = FLT_MOD;
      end else begin
        nx_paddr  = {cam_pfn, lk_vaddr[OFF_W-1:0]};
        nx_cached = !cam_nc;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_paddr  <= '0;
      rsp_hit    <= 1'b0;
      rsp_cached <= 1'b0;
      rsp_fault  <= FLT_NONE;
    end else begin
      rsp_valid  <= lk_valid;
      rsp_paddr  <= nx_paddr;
      rsp_hit    <= nx_hit;
      rsp_cached <= nx_cached;
      rsp_fault  <= nx_fault;
    end
  end
endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk #(
  parameter int ENTRIES = 64,
  parameter int WIRED   = 8,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int IDX_W   = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             lk_valid,
  input logic [VA_W-1:0]  lk_vaddr,
  input logic             lk_store,
  input logic             lk_user,
  input logic [PA_W-1:0]  rsp_paddr,
  input logic             rsp_hit,
  input logic             rsp_cached,
  input logic [1:0]       rsp_fault,
  input logic [IDX_W-1:0] rand_idx
);
  AST_DIRECT_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && !lk_user && lk_vaddr[VA_W-1 -: 2] == 2'b10) |=>
      (!rsp_hit && rsp_fault == 2'd0 &&
       rsp_cached == !$past(lk_vaddr[VA_W-3]) &&
       rsp_paddr[VA_W-4:0] == $past(lk_vaddr[VA_W-4:0]))); // R2

  AST_HIT_NO_MISS: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> (rsp_fault == 2'd0 || rsp_fault == 2'd2)); // R3

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rsp_fault == 2'd1) |-> (!rsp_hit && rsp_paddr == '0 && !rsp_cached)); // R4

  AST_MOD_ON_STORE: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && !lk_store) |=> (rsp_fault != 2'd2)); // R5

  AST_USER_KSEG: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_user && lk_vaddr[VA_W-1]) |=>
      (rsp_fault == 2'd3 && !rsp_hit && rsp_paddr == '0)); // R6

  AST_RAND_RANGE: assert property (@(posedge clk) disable iff (rst)
    (rand_idx >= IDX_W'(WIRED) && rand_idx <= IDX_W'(ENTRIES - 1))); // R7

  AST_RAND_STEP: assert property (@(posedge clk) disable iff (rst)
    (rand_idx != IDX_W'(WIRED)) |=> (rand_idx == $past(rand_idx) - 1'b1)); // R7
endmodule

bind asid_tlb asid_tlb_chk #(
  .ENTRIES(ENTRIES), .WIRED(WIRED), .VA_W(VA_W), .PA_W(PA_W), .IDX_W(IDX_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .lk_valid  (lk_valid),
  .lk_vaddr  (lk_vaddr),
  .lk_store  (lk_store),
  .lk_user   (lk_user),
  .rsp_paddr (rsp_paddr),
  .rsp_hit   (rsp_hit),
  .rsp_cached(rsp_cached),
  .rsp_fault (rsp_fault),
  .rand_idx  (rand_idx)
);

// File: tb/tb_asid_tlb.sv
module tb_asid_tlb;
  localparam int N = 64;
  localparam int WR = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 0;
  logic [31:0] lk_vaddr = '0;
  logic [5:0]  lk_asid = '0;
  logic        lk_store = 0, lk_user = 0;
  logic        wr_en = 0, wr_random = 0;
  logic [5:0]  wr_index = '0;
  logic [19:0] wr_vpn = '0;
  logic [5:0]  wr_asid = '0;
  logic [19:0] wr_pfn = '0;
  logic        wr_global = 0, wr_dirty = 0, wr_nocache = 0, wr_valid = 0;
  logic        inv_en = 0;
  logic [19:0] inv_vpn = '0;
  logic        flush_all = 0;
  logic        rsp_valid, rsp_hit, rsp_cached;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_fault;
  logic [5:0]  rand_idx;

  asid_tlb dut (.*);

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  string tag = "";

  // Behavioural reference model
  logic        m_v [N];
  logic [19:0] m_vpn [N];
  logic [5:0]  m_asid [N];
  logic [19:0] m_pfn [N];
  logic        m_g [N], m_d [N], m_nc [N];
  int          m_rnd;
  logic        e_valid, e_hit, e_cached;
  logic [31:0] e_paddr;
  logic [1:0]  e_fault;
  string       e_tag;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) m_v[i] = 1'b0;
      m_rnd = N - 1;
      e_valid = 0; e_hit = 0; e_cached = 0; e_paddr = '0; e_fault = 2'd0;
      e_tag = "R1";
    end else begin
      int found;
      logic [2:0] top;
      top = lk_vaddr[31:29];
      e_valid = lk_valid; e_hit = 0; e_cached = 0; e_paddr = '0; e_fault = 2'd0;
      if (lk_user && top[2]) begin
        e_fault = 2'd3; e_tag = "R6";
      end else if (top == 3'b100 || top == 3'b101) begin
        e_paddr = {3'b000, lk_vaddr[28:0]}; e_cached = (top == 3'b100); e_tag = "R2";
      end else begin
        found = -1;
        for (int i = 0; i < N; i++)
          if (found < 0 && m_v[i] && m_vpn[i] == lk_vaddr[31:12] &&
              (m_g[i] || m_asid[i] == lk_asid)) found = i;
        if (found < 0) begin
          e_fault = 2'd1; e_tag = "R4";
        end else begin
          e_hit = 1;
          if (lk_store && !m_d[found]) begin
            e_fault = 2'd2; e_tag = "R5";
          end else begin
            e_paddr = {m_pfn[found], lk_vaddr[11:0]}; e_cached = !m_nc[found]; e_tag = "R3";
          end
        end
      end
      if (flush_all) for (int i = 0; i < N; i++) m_v[i] = 1'b0;
      if (inv_en) for (int i = 0; i < N; i++) if (m_vpn[i] == inv_vpn) m_v[i] = 1'b0;
      if (wr_en) begin
        int k;
        k = wr_random ? m_rnd : int'(wr_index);
        m_v[k] = wr_valid; m_vpn[k] = wr_vpn; m_asid[k] = wr_asid; m_pfn[k] = wr_pfn;
        m_g[k] = wr_global; m_d[k] = wr_dirty; m_nc[k] = wr_nocache;
      end
      m_rnd = (m_rnd == WR) ? N - 1 : m_rnd - 1;
    end
  end

  task automatic compare();
    string t;
    t = (tag != "") ? tag : e_tag;
    checks++;
    if (rand_idx != 6'(m_rnd) || rsp_valid != e_valid) begin
      errors++;
      $display("FAIL R7 rand_idx=%0d exp=%0d valid=%0b exp=%0b", rand_idx, m_rnd, rsp_valid, e_valid);
    end
    if (e_valid) begin
      checks++;
      if (rsp_hit != e_hit || rsp_paddr != e_paddr || rsp_cached != e_cached || rsp_fault != e_fault) begin
        errors++;
        $display("FAIL %s hit=%0b paddr=%h cached=%0b fault=%0d exp hit=%0b paddr=%h cached=%0b fault=%0d",
                 t, rsp_hit, rsp_paddr, rsp_cached, rsp_fault, e_hit, e_paddr, e_cached, e_fault);
      end
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
    compare();
  endtask

  task automatic look(input logic [31:0] va, input logic [5:0] as, input logic st, input logic us);
    lk_valid = 1; lk_vaddr = va; lk_asid = as; lk_store = st; lk_user = us;
  endtask

  task automatic put(input logic rnd, input logic [5:0] idx, input logic [19:0] vpn,
                     input logic [5:0] as, input logic [19:0] pfn,
                     input logic g, input logic d, input logic nc);
    wr_en = 1; wr_random = rnd; wr_index = idx; wr_vpn = vpn; wr_asid = as; wr_pfn = pfn;
    wr_global = g; wr_dirty = d; wr_nocache = nc; wr_valid = 1;
  endtask

  task automatic idle();
    lk_valid = 0; wr_en = 0; inv_en = 0; flush_all = 0;
  endtask

  logic done = 0;
  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    checks++;
    if (rsp_valid !== 1'b0 || rand_idx !== 6'd63) begin
      errors++;
      $display("FAIL R1 valid=%0b rand=%0d exp 0 63", rsp_valid, rand_idx);
    end
    rst = 0;
    tag = "R1"; look(32'h0012_3456, 6'd5, 0, 1); tick();
    tag = "";
    // R2: direct windows
    look(32'h8123_4567, 6'd0, 0, 0); tick();
    look(32'hA765_4321, 6'd0, 1, 0); tick();
    idle();
    // fill entries
    put(0, 6'd10, 20'h00123, 6'd5, 20'hABCDE, 0, 1, 0); tick();
    put(0, 6'd11, 20'h00200, 6'd0, 20'h11111, 1, 0, 1); tick();
    put(0, 6'd12, 20'hC0000, 6'd3, 20'h22222, 1, 1, 0); tick();
    idle();
    look(32'h0012_3ABC, 6'd5, 1, 1); tick();   // R3 hit
    look(32'h0012_3ABC, 6'd6, 0, 1); tick();   // R4 asid mismatch
    look(32'h0020_0010, 6'd9, 0, 1); tick();   // R3 global, uncached
    look(32'h0020_0010, 6'd9, 1, 1); tick();   // R5 modify fault
    look(32'hC000_0044, 6'd1, 0, 1); tick();   // R6 user into kernel
    look(32'hC000_0044, 6'd1, 1, 0); tick();   // R3 kernel mapped
    // R11: write and lookup on same edge
    tag = "R11";
    put(0, 6'd13, 20'h00333, 6'd2, 20'h33333, 0, 1, 0);
    look(32'h0033_3008, 6'd2, 0, 1); tick();
    idle(); look(32'h0033_3008, 6'd2, 0, 1); tick();
    // R8: random replacement
    tag = "R8";
    idle(); put(1, 6'd0, 20'h00300, 6'd5, 20'h44444, 0, 1, 0); tick();
    idle(); look(32'h0030_0FFF, 6'd5, 0, 1); tick();
    // R7: counter wrap
    tag = "R7"; idle();
    repeat (70) tick();
    // R9: invalidate by page
    tag = "R9";
    put(0, 6'd20, 20'h00400, 6'd1, 20'h55555, 0, 1, 0); tick();
    put(0, 6'd21, 20'h00400, 6'd2, 20'h66666, 0, 1, 0); tick();
    idle(); inv_en = 1; inv_vpn = 20'h00400; tick();
    idle(); look(32'h0040_0000, 6'd1, 0, 1); tick();
    look(32'h0040_0000, 6'd2, 0, 1); tick();
    look(32'h0012_3000, 6'd5, 0, 1); tick();
    // R10: flush with concurrent write
    tag = "R10";
    idle(); flush_all = 1; put(0, 6'd30, 20'h00500, 6'd4, 20'h77777, 0, 1, 1); tick();
    idle(); look(32'h0012_3000, 6'd5, 0, 1); tick();
    look(32'h0050_0123, 6'd4, 0, 1); tick();
    // mixed random traffic
    tag = "";
    for (int c = 0; c < 600; c++) begin
      logic [19:0] base, vp;
      idle();
      base = ($urandom % 2 == 0) ? 20'h00000 : 20'hC0000;
      if ($urandom % 4 == 0)
        put($urandom % 2 == 0, 6'($urandom), base | 20'($urandom % 8), 6'($urandom % 4),
            20'($urandom), 1'($urandom % 5 == 0), 1'($urandom), 1'($urandom));
      if ($urandom % 20 == 0) begin inv_en = 1; inv_vpn = base | 20'($urandom % 8); end
      if ($urandom % 60 == 0) flush_all = 1;
      case ($urandom % 4)
        0: vp = 20'h00000; 1: vp = 20'h80000; 2: vp = 20'hA0000; default: vp = 20'hC0000;
      endcase
      vp = vp | 20'($urandom % 8);
      look({vp, 12'($urandom)}, 6'($urandom % 4), 1'($urandom), 1'($urandom));
      tick();
    end
    idle(); tick();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule